// File: doc/BRIEF.md
# Dual-Channel Down-Counting Event Timer

The block holds two independent 64-bit down-counters behind a single-cycle 32-bit register port. Software loads an interval, picks a power-of-two tick divider, and starts a channel in periodic or one-shot mode. When a channel expires it raises a pending flag. The flags are masked by an enable register and ORed into one interrupt line. A channel loaded with all-ones in periodic mode serves as a free-running wrapping count source.

The register port writes when `bus_we` is high at a rising clock edge. Read data is combinational from `bus_addr`, and `bus_re` marks a read access. Channel n owns five words starting at byte offset 0x10 + 0x20·n.

Top module: `dctimer_top`

## Requirements
- R1: After reset every register reads zero and `irq` is low. The map is: interrupt enable at 0x00, pending status at 0x04, and for channel n, at base 0x10+0x20·n, control at +0x0, interval low at +0x4, interval high at +0x8, count low at +0xC, count high at +0x10.
- R2: Control bits: bit 0 run, bit 1 load, bits 6:4 divider select, bit 7 one-shot. A write with load set copies the 64-bit interval into the counter at the next clock edge. Load then reads back as 0, and the counter does not move while run is 0.
- R3: In one-shot mode, a tick that finds the counter at zero sets the pending flag, clears the run bit and halts the counter at zero. Starting with interval N, the flag appears N+1 ticks after the load edge.
- R4: In periodic mode, a tick that finds the counter at zero sets the pending flag and reloads the interval, so the flag repeats every N+1 ticks.
- R5: `irq` is high exactly when some channel has both its pending flag (status bit n) and its enable bit (bit n of 0x00) set. A pending flag whose enable is clear does not raise `irq`.
- R6: Writing 1 to status bit n clears that flag. Writing 0 leaves it unchanged.
- R7: If an expiry and a clearing write to the same flag fall on the same edge, the flag ends set.
- R8: After the edge that clears the run bit, the counter keeps counting for exactly two further clock edges and then stops.
- R9: Divider select p gives one tick every 2^p clock cycles, from a divider shared by both channels.
- R10: Reading count low captures the high 32 bits of the counter at that edge. Count high returns the captured value until the next count-low read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer source clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| irq | output | 1 | Shared interrupt request |

## Verification
The bench times expiry to the exact edge in both modes. An off-by-one expiry rule shifts the interrupt by one cycle, and a one-shot channel that fails to halt raises it again. A clearing write lands on the same edge as a periodic expiry; a design that lets the clear win loses that event. The bench measures the counting tail after the run bit drops, where an immediate stop or an over-long pipeline leaves a count other than 997. It also reads the count high word after the low word has wrapped: without the snapshot the high word comes back one lower than expected.

// File: rtl/dctimer_pkg.sv
package dctimer_pkg;
  localparam int unsigned PSC_W  = 3;
  localparam int unsigned PSC_N  = 1 << PSC_W;
  localparam int unsigned DIV_W  = PSC_N - 1;
  localparam int unsigned IE_OFF = 0;
  localparam int unsigned ST_OFF = 4;
  localparam int unsigned CH_BASE   = 16;
  localparam int unsigned CH_STRIDE = 32;

  typedef struct packed {
    logic             oneshot;
    logic [PSC_W-1:0] psc;
    logic             reload;
    logic             en;
  } ctl_t;

  typedef enum logic [2:0] {
    RG_CTL    = 3'd0,
    RG_IVL_LO = 3'd1,
    RG_IVL_HI = 3'd2,
    RG_CNT_LO = 3'd3,
    RG_CNT_HI = 3'd4
  } chreg_e;

  // Byte offset of one register of one channel.
  function automatic int unsigned chan_addr(input int unsigned ch, input chreg_e rg);
    return CH_BASE + CH_STRIDE * ch + 4 * int'(rg);
  endfunction

  // Low bits of the divider that must all be one for a tick at select p.
  function automatic logic [DIV_W-1:0] div_mask(input logic [PSC_W-1:0] p);
    return DIV_W'((1 << p) - 1);
  endfunction

  function automatic logic [31:0] ctl_to_word(input ctl_t c);
    return {24'd0, c.oneshot, c.psc, 2'b00, c.reload, c.en};
  endfunction

  function automatic ctl_t word_to_ctl(input logic [31:0] w);
    ctl_t c;
    c.en      = w[0];
    c.reload  = w[1];
    c.psc     = w[6:4];
    c.oneshot = w[7];
    return c;
  endfunction
endpackage

// File: rtl/dctimer_prescale.sv
module dctimer_prescale
  import dctimer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  output logic [PSC_N-1:0] tick
);
  logic [DIV_W-1:0] div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_q + 1'b1;
  end

  for (genvar p = 0; p < PSC_N; p++) begin : g_tap
    assign tick[p] = ((div_q & div_mask(PSC_W'(p))) == div_mask(PSC_W'(p)));
    if (p > 0) begin : g_nest
      // R9: a slower tap only fires on a cycle where the next faster one fires
      a_r9_tap_nested: assert property (@(posedge clk) disable iff (!rst_n)
        tick[p] |-> tick[p-1]);
    end
  end
endmodule

// File: rtl/dctimer_chan.sv
module dctimer_chan
  import dctimer_pkg::*;
#(
  parameter int unsigned CNT_W    = 64,
  parameter int unsigned STOP_LAT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PSC_N-1:0] ticks,
  input  logic             ctl_we,
  input  ctl_t             ctl_wdata,
  input  logic             ivl_lo_we,
  input  logic             ivl_hi_we,
  input  logic [31:0]      wdata,
  output ctl_t             ctl_q,
  output logic [CNT_W-1:0] ivl_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             expire
);
  localparam int unsigned HI_W = CNT_W - 32;

  logic [STOP_LAT-1:0] en_dly;
  logic active, step, at_zero, os_done;

  assign active  = ctl_q.en | (|en_dly);
  assign step    = active & ticks[ctl_q.psc] & ~ctl_q.reload;
  assign at_zero = (cnt_q == '0);
  assign expire  = step & at_zero;
  assign os_done = expire & ctl_q.oneshot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (ctl_we) begin
      ctl_q <= ctl_wdata;
    end else begin
      if (ctl_q.reload) ctl_q.reload <= 1'b0;
      if (os_done)      ctl_q.en     <= 1'b0;
    end
  end

  // Run bit drains through a short pipe so a stop lands STOP_LAT edges late.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_dly <= '0;
    end else if (os_done && !ctl_we) begin
      en_dly <= '0;
    end else begin
      en_dly[0] <= ctl_q.en;
      for (int i = 1; i < STOP_LAT; i++) en_dly[i] <= en_dly[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ivl_q <= '0;
    end else begin
      if (ivl_lo_we) ivl_q[31:0]      <= wdata;
      if (ivl_hi_we) ivl_q[CNT_W-1:32] <= wdata[HI_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (ctl_q.reload)  cnt_q <= ivl_q;
    else if (expire)        cnt_q <= ctl_q.oneshot ? cnt_q : ivl_q;
    else if (step)          cnt_q <= cnt_q - 1'b1;
  end

  a_r2_load_done: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q.reload && !ctl_we && !ivl_lo_we && !ivl_hi_we)
      |=> (!ctl_q.reload && cnt_q == $past(ivl_q)));

  a_r3_oneshot_halt: assert property (@(posedge clk) disable iff (!rst_n)
    (os_done && !ctl_we) |=> (!active && at_zero));

  a_r4_periodic_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !ctl_q.oneshot) |=> (cnt_q == $past(ivl_q)));

  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !ctl_q.reload) |=> $stable(cnt_q));
endmodule

// File: rtl/dctimer_top.sv
module dctimer_top
  import dctimer_pkg::*;
#(
  parameter int unsigned NUM_CH   = 2,
  parameter int unsigned CNT_W    = 64,
  parameter int unsigned STOP_LAT = 2,
  parameter int unsigned ADDR_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);
  localparam int unsigned HI_W = CNT_W - 32;

  logic [PSC_N-1:0]  ticks;
  ctl_t              ctl_a [NUM_CH];
  logic [CNT_W-1:0]  ivl_a [NUM_CH];
  logic [CNT_W-1:0]  cnt_a [NUM_CH];
  logic [NUM_CH-1:0] expire;
  logic [NUM_CH-1:0] ctl_we, lo_we, hi_we, lo_rd;
  logic [NUM_CH-1:0] ie_q, sts_q, w1c_mask;
  logic [NUM_CH-1:0][HI_W-1:0] snap_q;
  logic ie_we, st_we;

  dctimer_prescale u_div (.clk(clk), .rst_n(rst_n), .tick(ticks));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign ctl_we[c] = bus_we && (bus_addr == ADDR_W'(chan_addr(c, RG_CTL)));
    assign lo_we[c]  = bus_we && (bus_addr == ADDR_W'(chan_addr(c, RG_IVL_LO)));
    assign hi_we[c]  = bus_we && (bus_addr == ADDR_W'(chan_addr(c, RG_IVL_HI)));
    assign lo_rd[c]  = bus_re && (bus_addr == ADDR_W'(chan_addr(c, RG_CNT_LO)));

    dctimer_chan #(.CNT_W(CNT_W), .STOP_LAT(STOP_LAT)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .ticks    (ticks),
      .ctl_we   (ctl_we[c]),
      .ctl_wdata(word_to_ctl(bus_wdata)),
      .ivl_lo_we(lo_we[c]),
      .ivl_hi_we(hi_we[c]),
      .wdata    (bus_wdata),
      .ctl_q    (ctl_a[c]),
      .ivl_q    (ivl_a[c]),
      .cnt_q    (cnt_a[c]),
      .expire   (expire[c])
    );

    a_r7_expire_sets: assert property (@(posedge clk) disable iff (!rst_n)
      expire[c] |=> sts_q[c]);

    a_r6_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (w1c_mask[c] && !expire[c]) |=> !sts_q[c]);

    a_r10_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !lo_rd[c] |=> $stable(snap_q[c]));
  end

  assign ie_we    = bus_we && (bus_addr == ADDR_W'(IE_OFF));
  assign st_we    = bus_we && (bus_addr == ADDR_W'(ST_OFF));
  assign w1c_mask = st_we ? bus_wdata[NUM_CH-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q  <= '0;
      sts_q <= '0;
    end else begin
      if (ie_we) ie_q <= bus_wdata[NUM_CH-1:0];
      sts_q <= (sts_q & ~w1c_mask) | expire;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= '0;
    end else begin
      for (int c = 0; c < NUM_CH; c++)
        if (lo_rd[c]) snap_q[c] <= cnt_a[c][CNT_W-1:32];
    end
  end

  assign irq = |(sts_q & ie_q);

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(IE_OFF)) bus_rdata = 32'(ie_q);
    if (bus_addr == ADDR_W'(ST_OFF)) bus_rdata = 32'(sts_q);
    for (int c = 0; c < NUM_CH; c++) begin
      if (bus_addr == ADDR_W'(chan_addr(c, RG_CTL)))    bus_rdata = ctl_to_word(ctl_a[c]);
      if (bus_addr == ADDR_W'(chan_addr(c, RG_IVL_LO))) bus_rdata = ivl_a[c][31:0];
      if (bus_addr == ADDR_W'(chan_addr(c, RG_IVL_HI))) bus_rdata = 32'(ivl_a[c][CNT_W-1:32]);
      if (bus_addr == ADDR_W'(chan_addr(c, RG_CNT_LO))) bus_rdata = cnt_a[c][31:0];
      if (bus_addr == ADDR_W'(chan_addr(c, RG_CNT_HI))) bus_rdata = 32'(snap_q[c]);
    end
  end
endmodule

// File: tb/sim_dctimer_top.sv
module sim_dctimer_top;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0, rst_n = 1'b0, we = 1'b0, re = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  wire  [31:0] rdata;
  wire         irq;

  always #(CLK_NS/2) clk = ~clk;

  dctimer_top u0 (.clk(clk), .rst_n(rst_n), .bus_we(we), .bus_re(re),
                  .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq));

  typedef struct { logic [31:0] v; string tag; } exp_t;
  exp_t exp_q[$];
  int checks = 0, errors = 0;

  function automatic logic [7:0] ra(input int ch, input int rg);
    return 8'(16 + 32 * ch + 4 * rg);
  endfunction

  // Monitor: every read cycle pops one expected word from the scoreboard.
  always @(negedge clk) begin
    if (re) begin
      exp_t e;
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL scoreboard empty: got %h exp none", rdata);
      end else begin
        e = exp_q.pop_front();
        if (rdata !== e.v) begin
          errors++;
          $display("FAIL %s: got %h exp %h", e.tag, rdata, e.v);
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1; we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] v, input string tag);
    exp_t e;
    e.v = v; e.tag = tag;
    @(posedge clk); #1; re = 1'b1; addr = a; exp_q.push_back(e);
    @(posedge clk); #1; re = 1'b0;
  endtask

  task automatic peek(input logic [7:0] a, output logic [31:0] v);
    @(posedge clk); #1; addr = a;
    @(negedge clk); v = rdata;
  endtask

  task automatic chk(input logic got, input logic exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0b exp %0b", tag, got, exp);
    end
  endtask

  task automatic chk_word(input logic [31:0] got, input logic [31:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0d exp %0d", tag, got, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] a0, b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    rd(8'h00, 32'h0, "R1 ie");
    rd(8'h04, 32'h0, "R1 status");
    rd(ra(0, 0), 32'h0, "R1 ctl0");
    rd(ra(1, 0), 32'h0, "R1 ctl1");
    rd(ra(0, 3), 32'h0, "R1 cnt0 lo");
    @(negedge clk); chk(irq, 1'b0, "R1 irq");

    // R2 load without run
    wr(ra(0, 1), 32'd10);
    wr(ra(0, 2), 32'd0);
    wr(ra(0, 0), 32'h02);
    rd(ra(0, 3), 32'd10, "R2 loaded");
    rd(ra(0, 0), 32'h0, "R2 load self-clear");
    repeat (5) @(posedge clk);
    rd(ra(0, 3), 32'd10, "R2 no count");

    // R3 one-shot, interval 5: flag after edge 8 counted from the write edge
    wr(8'h00, 32'h1);
    wr(ra(0, 1), 32'd5);
    wr(ra(0, 0), 32'h83);
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk);
      chk(irq, k >= 8, $sformatf("R3 oneshot irq k=%0d", k));
    end
    rd(ra(0, 0), 32'h80, "R3 run cleared");
    rd(ra(0, 3), 32'h0, "R3 halted at zero");
    rd(8'h04, 32'h1, "R3 status");
    wr(8'h04, 32'h1);
    @(negedge clk); chk(irq, 1'b0, "R6 w1c after oneshot");

    // R4 periodic, interval 3: expiries at edges 6, 10, 14
    wr(ra(0, 1), 32'd3);
    wr(ra(0, 0), 32'h03);
    for (int k = 1; k <= 7; k++) begin
      @(negedge clk);
      chk(irq, k >= 6, $sformatf("R4 periodic irq k=%0d", k));
    end
    wr(8'h04, 32'h1);
    @(negedge clk); chk(irq, 1'b0, "R6 cleared before second expiry");
    @(negedge clk); chk(irq, 1'b1, "R4 second expiry");
    wr(8'h04, 32'h1);
    @(negedge clk); chk(irq, 1'b0, "R6 cleared");
    wr(8'h04, 32'h1);
    @(negedge clk); chk(irq, 1'b1, "R7 set beats clear");

    // R8 stop tail: two extra decrements after the stopping edge
    wr(ra(0, 1), 32'd1000);
    wr(ra(0, 0), 32'h03);
    wr(ra(0, 0), 32'h00);
    repeat (6) @(posedge clk);
    rd(ra(0, 3), 32'd997, "R8 stop latency");
    rd(ra(0, 0), 32'h0, "R8 ctl stopped");

    // R9 divider: ticks in a 64-cycle window
    wr(ra(0, 1), 32'd100000);
    wr(ra(0, 0), 32'h23);
    repeat (4) @(posedge clk);
    peek(ra(0, 3), a0);
    repeat (63) @(posedge clk);
    peek(ra(0, 3), b0);
    chk_word(a0 - b0, 32'd16, "R9 div by 4");
    wr(ra(0, 0), 32'h53);
    repeat (4) @(posedge clk);
    peek(ra(0, 3), a0);
    repeat (63) @(posedge clk);
    peek(ra(0, 3), b0);
    chk_word(a0 - b0, 32'd2, "R9 div by 32");

    // R10 high-word snapshot across a low-word wrap
    wr(ra(1, 1), 32'd2);
    wr(ra(1, 2), 32'd5);
    wr(ra(1, 0), 32'h03);
    @(posedge clk);
    rd(ra(1, 3), 32'h1, "R10 lo before wrap");
    rd(ra(1, 4), 32'h5, "R10 hi snapshot held");
    rd(ra(1, 3), 32'hFFFF_FFFD, "R10 lo after wrap");
    rd(ra(1, 4), 32'h4, "R10 hi after wrap");

    // R5 masking
    wr(ra(0, 0), 32'h0);
    wr(ra(1, 0), 32'h0);
    repeat (4) @(posedge clk);
    wr(8'h04, 32'h3);
    wr(ra(1, 1), 32'd2);
    wr(ra(1, 2), 32'd0);
    wr(ra(1, 0), 32'h03);
    repeat (10) @(posedge clk);
    rd(8'h04, 32'h2, "R5 ch1 pending");
    @(negedge clk); chk(irq, 1'b0, "R5 masked");
    wr(8'h00, 32'h3);
    @(negedge clk); chk(irq, 1'b1, "R5 unmasked");

    repeat (2) @(posedge clk);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard: got %0d left exp 0", exp_q.size());
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule